// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a 16-bit narrow port A and a 32-bit wide port B. Port B is handled as two 16-bit halves, called the first half (1B) and the second half (2B). Every storage register loads on the rising edge of a single clock.

In the A-to-B direction, narrow words arrive on consecutive clocks and are gathered into one wide word. The path from A to the first half has two register stages. The path from A to the second half has one. Because of this, a word presented first comes out on the first half in the same cycle as the word presented next comes out on the second half. In the B-to-A direction, both halves of port B are registered, and a select input chooses which registered half drives port A.

The direction input is itself registered, so the bus turns around only at a clock edge. An active-low output enable gates every output-enable signal. Two per-byte mask bits freeze a byte lane in every data register. The block models tri-state drive as a data output plus a separate enable signal.

Top module: `bus_xchg`

## Requirements
- R1: A synchronous active-low reset clears every data register to zero and sets the registered direction to B-to-A (0). Right after reset with `oe_n` low, `a_oe` is 1, `b_oe` is 0, and all data outputs read zero.
- R2: With no mask bits set, `b2_out` shows the `a_in` value sampled at the previous rising edge (one register stage).
- R3: With no mask bits set, `b1_out` shows the `a_in` value sampled two rising edges earlier (two register stages).
- R4: If words W0 and then W1 are driven on `a_in` on consecutive clocks with no masks set, the cycle after W1 is captured shows `b1_out`=W0 and `b2_out`=W1 together.
- R5: `b1_in` and `b2_in` are registered on each rising edge. `a_out` shows the registered first half when `sel`=0 and the registered second half when `sel`=1. A change of `sel` appears on `a_out` in the same cycle, with no clock edge needed.
- R6: `dir` is sampled on the rising edge. A change on `dir` affects `a_oe`/`b_oe` only after the next rising edge.
- R7: While `oe_n` is 1, `a_oe` and `b_oe` are both 0, whatever the direction.
- R8: While `oe_n` is 0, a registered direction of 1 (A-to-B) gives `b_oe`=1 and `a_oe`=0. A registered direction of 0 (B-to-A) gives `a_oe`=1 and `b_oe`=0.
- R9: `mask[0]` covers byte lane [7:0] and `mask[1]` covers byte lane [15:8]. While a mask bit is 1 at a rising edge, that byte lane keeps its previous value in every data register: both A-to-B stages, the second-half register, and both B-side registers. The other lane loads normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | Direction request, 1 = A-to-B, 0 = B-to-A; registered |
| sel | input | 1 | B-to-A half select, 0 = first half, 1 = second half |
| mask | input | 2 | Per-byte load inhibit, bit 0 = [7:0], bit 1 = [15:8] |
| a_in | input | 16 | Narrow port input data |
| a_out | output | 16 | Narrow port output data |
| a_oe | output | 1 | Narrow port drive enable |
| b1_in | input | 16 | Wide port first-half input data |
| b2_in | input | 16 | Wide port second-half input data |
| b1_out | output | 16 | Wide port first-half output data |
| b2_out | output | 16 | Wide port second-half output data |
| b_oe | output | 1 | Wide port drive enable |

## Verification
The bench feeds back-to-back narrow words and checks that the first word and the following word appear together on the wide halves. A design whose two paths had equal depth would show the same word on both halves, or shift the words by a cycle. It flips `sel` with no clock edge in between and expects `a_out` to follow at once, which catches a select that was registered by mistake. It changes `dir` and checks that the enables turn around only after the next edge, which catches a direction input used without its register. It sets each mask bit alone on both directions and expects exactly that byte lane to hold in every stage. That test finds a mask that is ignored, a mask applied to the wrong lane, or a mask that skips the second pipeline stage.

// File: rtl/bx_pkg.sv
// Shared definitions for the bus exchanger.
// Assumes the narrow width is a whole number of bytes.
package bx_pkg;
    localparam int BX_BYTE_W = 8;

    typedef enum logic {
        BX_B2A = 1'b0,
        BX_A2B = 1'b1
    } bx_dir_e;
endpackage

// File: rtl/bx_mask_reg.sv
// Byte-lane register with a per-lane load inhibit.
// What it does: each lane loads d on the rising edge unless its mask bit is set.
// Assumes: synchronous active-low reset clears every lane to zero.
module bx_mask_reg #(
    parameter int NBYTES = 2,
    parameter int BYTE_W = 8,
    localparam int W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] mask,
    input  logic [W-1:0]      d,
    output logic [W-1:0]      q
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        // Load one byte lane, or hold it while its mask bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i*BYTE_W +: BYTE_W] <= '0;
            else if (!mask[i])
                q[i*BYTE_W +: BYTE_W] <= d[i*BYTE_W +: BYTE_W];
        end

        // R9: a masked lane keeps its value across the edge
        a_r9_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && mask[i]) |=> (q[i*BYTE_W +: BYTE_W] == $past(q[i*BYTE_W +: BYTE_W])));
    end
endmodule

// File: rtl/bx_a2b_path.sv
// Narrow-to-wide path.
// What it does: two register stages toward the first half and one toward the second half.
// This lets two consecutive narrow words line up on one wide word.
// Assumes: every stage obeys the same byte mask.
module bx_a2b_path #(
    parameter int NBYTES = 2,
    parameter int BYTE_W = 8,
    localparam int W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] mask,
    input  logic [W-1:0]      a_in,
    output logic [W-1:0]      b1_q,
    output logic [W-1:0]      b2_q
);
    logic [W-1:0] stage1;

    // First stage toward the first half
    bx_mask_reg #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_st1 (
        .clk(clk), .rst_n(rst_n), .mask(mask), .d(a_in), .q(stage1));

    // Second stage toward the first half
    bx_mask_reg #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_st2 (
        .clk(clk), .rst_n(rst_n), .mask(mask), .d(stage1), .q(b1_q));

    // Single stage toward the second half
    bx_mask_reg #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_half2 (
        .clk(clk), .rst_n(rst_n), .mask(mask), .d(a_in), .q(b2_q));

    // R2: the second half trails a_in by exactly one edge
    a_r2_half2_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mask == '0) |=> (b2_q == $past(a_in)));

    // R3: the first half's final stage takes what the first stage held
    a_r3_half1_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mask == '0) |=> (b1_q == $past(stage1)));
endmodule

// File: rtl/bx_b2a_path.sv
// Wide-to-narrow path.
// What it does: registers both wide halves and picks one for the narrow port.
// Assumes: the select acts combinationally on the registered data.
module bx_b2a_path #(
    parameter int NBYTES = 2,
    parameter int BYTE_W = 8,
    localparam int W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] mask,
    input  logic              sel,
    input  logic [W-1:0]      b1_in,
    input  logic [W-1:0]      b2_in,
    output logic [W-1:0]      a_q
);
    logic [W-1:0] rb1;
    logic [W-1:0] rb2;

    // Capture register for the first half
    bx_mask_reg #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_rb1 (
        .clk(clk), .rst_n(rst_n), .mask(mask), .d(b1_in), .q(rb1));

    // Capture register for the second half
    bx_mask_reg #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_rb2 (
        .clk(clk), .rst_n(rst_n), .mask(mask), .d(b2_in), .q(rb2));

    // Half selection onto the narrow port
    always_comb begin
        a_q = sel ? rb2 : rb1;
    end

    // R5: with sel low across an edge, the narrow port shows the registered first half
    a_r5_sel_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mask == '0 && !sel) |=> (sel || a_q == $past(b1_in)));
endmodule

// File: rtl/bus_xchg.sv
// Narrow-to-wide registered bus exchanger, top level.
// What it does: joins the two data paths and holds the registered direction.
// From that direction and oe_n it derives the port drive enables.
// Assumes: tri-state drive is shown as data outputs plus separate enables.
module bus_xchg #(
    parameter int NARROW_W = 16,
    parameter int BYTE_W   = bx_pkg::BX_BYTE_W,
    localparam int NBYTES  = NARROW_W / BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                oe_n,
    input  logic                dir,
    input  logic                sel,
    input  logic [NBYTES-1:0]   mask,
    input  logic [NARROW_W-1:0] a_in,
    output logic [NARROW_W-1:0] a_out,
    output logic                a_oe,
    input  logic [NARROW_W-1:0] b1_in,
    input  logic [NARROW_W-1:0] b2_in,
    output logic [NARROW_W-1:0] b1_out,
    output logic [NARROW_W-1:0] b2_out,
    output logic                b_oe
);
    import bx_pkg::*;

    bx_dir_e dir_q;

    // Register the direction request so turnaround happens on an edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= BX_B2A;
        else
            dir_q <= bx_dir_e'(dir);
    end

    // Drive enables from the registered direction and the output enable
    always_comb begin
        a_oe = !oe_n && (dir_q == BX_B2A);
        b_oe = !oe_n && (dir_q == BX_A2B);
    end

    bx_a2b_path #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_a2b (
        .clk(clk), .rst_n(rst_n), .mask(mask), .a_in(a_in),
        .b1_q(b1_out), .b2_q(b2_out));

    bx_b2a_path #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_b2a (
        .clk(clk), .rst_n(rst_n), .mask(mask), .sel(sel),
        .b1_in(b1_in), .b2_in(b2_in), .a_q(a_out));

    // R6, R8: a requested A-to-B turn shows on the enables one edge later
    a_r6_dir_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && dir) |=> (oe_n || (b_oe && !a_oe)));

    // R7: a high output enable leaves both ports undriven
    a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe));
endmodule

// File: tb/tb_bus_xchg.sv
module tb_bus_xchg;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          oe_n = 1'b0;
    logic          dir = 1'b0;
    logic          sel = 1'b0;
    logic [1:0]    mask = 2'b00;
    logic [NW-1:0] a_in = '0;
    logic [NW-1:0] b1_in = '0;
    logic [NW-1:0] b2_in = '0;
    logic [NW-1:0] a_out, b1_out, b2_out;
    logic          a_oe, b_oe;

    int total = 0;
    int bad = 0;

    typedef struct {
        int            req;
        logic [NW-1:0] a;
        logic          aoe;
        logic [NW-1:0] b1;
        logic [NW-1:0] b2;
        logic          boe;
    } exp_t;

    exp_t sb[$];

    // Bench model, built from the requirements
    logic [NW-1:0] m_s1 = '0, m_s2 = '0, m_h2 = '0, m_rb1 = '0, m_rb2 = '0;
    logic          m_dir = 1'b0;

    bus_xchg dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel(sel),
        .mask(mask), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b2_in(b2_in), .b1_out(b1_out), .b2_out(b2_out),
        .b_oe(b_oe));

    always #10 clk = ~clk;

    function automatic logic [NW-1:0] merge(logic [NW-1:0] old_v, logic [NW-1:0] new_v,
                                            logic [1:0] m);
        logic [NW-1:0] r;
        r[7:0]  = m[0] ? old_v[7:0]  : new_v[7:0];
        r[15:8] = m[1] ? old_v[15:8] : new_v[15:8];
        return r;
    endfunction

    // Driver: apply one cycle of stimulus and queue what must show after the edge
    task automatic step(int req, logic rst, logic oe, logic d, logic s, logic [1:0] m,
                        logic [NW-1:0] a, logic [NW-1:0] b1, logic [NW-1:0] b2);
        exp_t e;
        @(negedge clk);
        rst_n = rst; oe_n = oe; dir = d; sel = s; mask = m;
        a_in = a; b1_in = b1; b2_in = b2;
        if (!rst) begin
            m_s1 = '0; m_s2 = '0; m_h2 = '0; m_rb1 = '0; m_rb2 = '0; m_dir = 1'b0;
        end else begin
            m_s2  = merge(m_s2, m_s1, m);
            m_s1  = merge(m_s1, a, m);
            m_h2  = merge(m_h2, a, m);
            m_rb1 = merge(m_rb1, b1, m);
            m_rb2 = merge(m_rb2, b2, m);
            m_dir = d;
        end
        e.req = req;
        e.a   = s ? m_rb2 : m_rb1;
        e.aoe = !oe && !m_dir;
        e.boe = !oe && m_dir;
        e.b1  = m_s2;
        e.b2  = m_h2;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs a little after each rising edge
    always @(posedge clk) begin
        exp_t e;
        #5;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            total++;
            if (a_out !== e.a || a_oe !== e.aoe || b1_out !== e.b1 ||
                b2_out !== e.b2 || b_oe !== e.boe) begin
                bad++;
                $display("FAIL R%0d: a=%h/%b b1=%h b2=%h boe=%b exp a=%h/%b b1=%h b2=%h boe=%b",
                         e.req, a_out, a_oe, b1_out, b2_out, b_oe,
                         e.a, e.aoe, e.b1, e.b2, e.boe);
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 5000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        step(1, 0, 0, 1, 0, 2'b00, 16'h1111, 16'h2222, 16'h3333);
        step(1, 0, 0, 0, 0, 2'b00, 16'h4444, 16'h5555, 16'h6666);
        // R4, R2, R3: back-to-back words in A-to-B direction
        step(4, 1, 0, 1, 0, 2'b00, 16'hA0A0, 16'h0000, 16'h0000);
        step(4, 1, 0, 1, 0, 2'b00, 16'hA1A1, 16'h0000, 16'h0000);
        step(4, 1, 0, 1, 0, 2'b00, 16'hB0B0, 16'h0000, 16'h0000);
        step(2, 1, 0, 1, 0, 2'b00, 16'hB1B1, 16'h0000, 16'h0000);
        step(3, 1, 0, 1, 0, 2'b00, 16'h1234, 16'h0000, 16'h0000);
        step(3, 1, 0, 1, 0, 2'b00, 16'h5678, 16'h0000, 16'h0000);
        // R9: masks on the A-to-B path, each lane alone
        step(9, 1, 0, 1, 0, 2'b01, 16'hFFFF, 16'h0000, 16'h0000);
        step(9, 1, 0, 1, 0, 2'b10, 16'hEEEE, 16'h0000, 16'h0000);
        step(9, 1, 0, 1, 0, 2'b00, 16'hCAFE, 16'h0000, 16'h0000);
        // R7: output enable high blocks both ports
        step(7, 1, 1, 1, 0, 2'b00, 16'h0F0F, 16'h0000, 16'h0000);
        step(7, 1, 1, 0, 0, 2'b00, 16'hF0F0, 16'h0000, 16'h0000);
        // R6, R8: direction turns after the edge
        step(6, 1, 0, 1, 0, 2'b00, 16'h0000, 16'h0000, 16'h0000);
        step(6, 1, 0, 0, 0, 2'b00, 16'h0000, 16'hDEAD, 16'hBEEF);
        step(8, 1, 0, 0, 0, 2'b00, 16'h0000, 16'hDEAD, 16'hBEEF);
        // R5: select acts in the same cycle on registered halves
        step(5, 1, 0, 0, 1, 2'b00, 16'h0000, 16'h1357, 16'h2468);
        step(5, 1, 0, 0, 0, 2'b00, 16'h0000, 16'h1357, 16'h2468);
        step(5, 1, 0, 0, 1, 2'b00, 16'h0000, 16'h1357, 16'h2468);
        // R9: masks on the B-to-A path
        step(9, 1, 0, 0, 0, 2'b10, 16'h0000, 16'hAAAA, 16'hBBBB);
        step(9, 1, 0, 0, 1, 2'b01, 16'h0000, 16'hCCCC, 16'hDDDD);
        step(9, 1, 0, 0, 0, 2'b11, 16'h0000, 16'h9999, 16'h8888);
        step(8, 1, 0, 1, 0, 2'b00, 16'h7777, 16'h0000, 16'h0000);
        // R1: reset again from a busy state
        step(1, 0, 0, 1, 1, 2'b00, 16'h7777, 16'h1111, 16'h1111);
        // R5: select flips between edges, same cycle visibility
        step(5, 1, 0, 0, 0, 2'b00, 16'h0000, 16'h0A0B, 16'h0C0D);
        @(negedge clk);
        sel = 1'b1;
        #2;
        total++;
        if (a_out !== 16'h0C0D) begin
            bad++;
            $display("FAIL R5: a_out=%h expected=%h", a_out, 16'h0C0D);
        end
        repeat (3) @(posedge clk);
        #6;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule